// File: doc/BRIEF.md
# System Clock Source and Divider Controller

This block decides which of four clock sources feeds the system clock and how far that source is divided. It also keeps each source's oscillator powered on or off. Software programs it through a small two-register port. One register holds the requested source and divider, plus a second source/divider pair with an enable bit that takes effect on wake-up. The other register holds a per-source enable bit and a per-source bit that stops that source during sleep. Each source comes into the block as a tick (a clock-enable pulse in the block's own clock domain) and a ready flag. The block produces a divided system tick and one power-on request line per source.

A request to change source is taken up only once the new source is reported ready. The ready flags pass through a synchroniser first. Until the change is made, the old source keeps driving the system tick and stays powered, so the tick never shows a short or stray pulse. The block checks every source/divider pair against a legality table before accepting it. Sleep and wake events gate the system tick and the oscillators. When the wake-up enable bit is set, a wake event reloads the requested settings from the stored wake-up pair.

Top module: `clk_src_sel`

## Requirements
- R1: After reset, the selection register (reg_sel=0) reads 0x0000 and the power register (reg_sel=1) reads 0x00F1. That is, only source 0 is enabled and all four sleep-stop bits are 1. osc_on is 4'b0001.
- R2: The selection register has these fields: source in bits [1:0], divider code in [3:2], wake source in [5:4], wake divider code in [7:6], wake enable in [8]. Source codes are 0 fast-B, 1 slow, 2 fast-A and 3 external. Divider code d means divide by 2^d. A written pair is accepted and read back when it is legal: fast-A takes d=0..3, fast-B and slow take d=0..1, and external takes d=0 only.
- R3: A write whose active source/divider pair is illegal leaves the previously requested pair unchanged.
- R4: While awake, sys_tick pulses once for every 2^d ticks of the active source. Ticks of any other source have no effect.
- R5: A source change takes effect only after the new source's synchronised ready flag is high. Until then, the old source keeps driving sys_tick and its osc_on stays high.
- R6: While awake, osc_on[i] is high when source i is enabled (power register bit i), is the requested source, or is the active source.
- R7: While asleep, sys_tick stays low. osc_on[i] is forced low when sleep-stop bit i (power register bit 4+i) is 1, and otherwise keeps its awake value.
- R8: A wake event reloads the requested pair from the wake pair when the wake enable bit is 1. When the wake enable bit is 0, the requested pair is left as it was.
- R9: A wake pair is stored only if it is legal under the R2 table and its source is not code 1. Otherwise the stored wake pair is kept. The wake enable bit is always written.
- R10: If a wake reload and a write to the selection register fall in the same cycle, the reload sets the requested pair, and the written active pair is discarded.
- R11: A sleep event is honoured only while awake, and a wake event only while asleep. When the two arrive together, the one matching the current state wins.
- R12: Reserved bits read as 0: bits [15:9] of the selection register and bits [15:8] of the power register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 selection, 1 power |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the register chosen by reg_sel |
| src_ready | input | 4 | Per-source ready flags (asynchronous) |
| src_tick | input | 4 | Per-source clock-enable ticks |
| sleep_evt | input | 1 | Sleep entry event |
| wake_evt | input | 1 | Wake-up event |
| osc_on | output | 4 | Per-source oscillator run request |
| sys_tick | output | 1 | Divided system clock enable |

## Verification
Two functions can fall in the same cycle: a wake reload and a software write to the selection register. The bench provokes this by putting the block to sleep and then asserting wake_evt in the very cycle that carries a selection write. It judges the result from the read-back pair and from which source's ticks then reach sys_tick. Sleep and wake events are also issued in the wrong state, to show that they are ignored. Random selection writes, mixing legal and reserved pairs, are compared against a bench model of the legality table.

// File: rtl/clk_src_sel_pkg.sv
package clk_src_sel_pkg;

   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned SRC_W   = 2;
   localparam int unsigned DIV_W   = 2;
   localparam int unsigned CNT_W   = (1 << DIV_W) - 1;

   typedef enum logic [SRC_W-1:0] {
      SRC_FAST_B = 2'd0,
      SRC_SLOW   = 2'd1,
      SRC_FAST_A = 2'd2,
      SRC_EXT    = 2'd3
   } src_e;

   // legality of a source / divider-code pair for the active selection
   function automatic logic pair_ok(input logic [SRC_W-1:0] s, input logic [DIV_W-1:0] d);
      logic ok;
      case (s)
         SRC_FAST_B, SRC_SLOW: ok = (d <= 2'd1);
         SRC_FAST_A:           ok = 1'b1;
         default:              ok = (d == 2'd0);
      endcase
      return ok;
   endfunction

   // the wake pair may not name the slow oscillator
   function automatic logic wake_pair_ok(input logic [SRC_W-1:0] s, input logic [DIV_W-1:0] d);
      return (s != SRC_SLOW) && pair_ok(s, d);
   endfunction

endpackage

// File: rtl/clk_src_sel_regs.sv
module clk_src_sel_regs
   import clk_src_sel_pkg::*;
#(
   parameter int unsigned   DATA_W   = 16,
   parameter logic [3:0]    RST_EN   = 4'b0001,
   parameter logic [3:0]    RST_STOP = 4'b1111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 reg_sel,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 wake_fire,
   output logic [DATA_W-1:0]    rdata,
   output logic [SRC_W-1:0]     req_src,
   output logic [DIV_W-1:0]     req_div,
   output logic [SRC_W-1:0]     wk_src,
   output logic [DIV_W-1:0]     wk_div,
   output logic [NUM_SRC-1:0]   osc_en,
   output logic [NUM_SRC-1:0]   sleep_stop
);

   localparam int unsigned SEL_FIELDS_W = 2 * (SRC_W + DIV_W) + 1;
   localparam int unsigned PWR_FIELDS_W = 2 * NUM_SRC;

   logic                wk_mode;
   logic                wr_sel;
   logic                wr_pwr;
   logic [SRC_W-1:0]    w_src;
   logic [DIV_W-1:0]    w_div;
   logic [SRC_W-1:0]    w_wsrc;
   logic [DIV_W-1:0]    w_wdiv;

   assign wr_sel = wr_en && !reg_sel;
   assign wr_pwr = wr_en &&  reg_sel;
   assign w_src  = wdata[1:0];
   assign w_div  = wdata[3:2];
   assign w_wsrc = wdata[5:4];
   assign w_wdiv = wdata[7:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_src <= '0;
         req_div <= '0;
      end else if (wake_fire && wk_mode) begin
         req_src <= wk_src;
         req_div <= wk_div;
      end else if (wr_sel && pair_ok(w_src, w_div)) begin
         req_src <= w_src;
         req_div <= w_div;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_src  <= '0;
         wk_div  <= '0;
         wk_mode <= 1'b0;
      end else if (wr_sel) begin
         wk_mode <= wdata[8];
         if (wake_pair_ok(w_wsrc, w_wdiv)) begin
            wk_src <= w_wsrc;
            wk_div <= w_wdiv;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_en     <= RST_EN;
         sleep_stop <= RST_STOP;
      end else if (wr_pwr) begin
         osc_en     <= wdata[NUM_SRC-1:0];
         sleep_stop <= wdata[2*NUM_SRC-1:NUM_SRC];
      end
   end

   always_comb begin
      rdata = '0;
      if (!reg_sel) begin
         rdata[SEL_FIELDS_W-1:0] = {wk_mode, wk_div, wk_src, req_div, req_src};
      end else begin
         rdata[PWR_FIELDS_W-1:0] = {sleep_stop, osc_en};
      end
   end

endmodule

// File: rtl/clk_src_sel_power.sv
module clk_src_sel_power
   import clk_src_sel_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_evt,
   input  logic                 wake_evt,
   input  logic [NUM_SRC-1:0]   osc_en,
   input  logic [NUM_SRC-1:0]   sleep_stop,
   input  logic [SRC_W-1:0]     req_src,
   input  logic [SRC_W-1:0]     cur_src,
   output logic                 asleep,
   output logic                 wake_fire,
   output logic [NUM_SRC-1:0]   osc_on
);

   assign wake_fire = wake_evt && asleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep <= 1'b0;
      end else if (asleep) begin
         if (wake_evt) asleep <= 1'b0;
      end else if (sleep_evt) begin
         asleep <= 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_osc
      logic wanted;
      assign wanted    = osc_en[i] || (req_src == SRC_W'(i)) || (cur_src == SRC_W'(i));
      assign osc_on[i] = wanted && !(asleep && sleep_stop[i]);
   end

endmodule

// File: rtl/clk_src_sel_switch.sv
module clk_src_sel_switch
   import clk_src_sel_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SRC_W-1:0]     req_src,
   input  logic [DIV_W-1:0]     req_div,
   input  logic [NUM_SRC-1:0]   src_ready,
   input  logic [NUM_SRC-1:0]   src_tick,
   input  logic                 asleep,
   output logic [SRC_W-1:0]     cur_src,
   output logic [DIV_W-1:0]     cur_div,
   output logic [NUM_SRC-1:0]   rdy_s,
   output logic                 sys_tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic             run;
   logic             tick_cur;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rdy_s = src_ready;
   end else begin : g_sync
      logic [NUM_SRC-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
         end else begin
            chain[0] <= src_ready;
            for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         end
      end
      assign rdy_s = chain[SYNC_STAGES-1];
   end

   assign run      = !asleep && rdy_s[cur_src];
   assign tick_cur = src_tick[cur_src];
   assign mask     = CNT_W'((1 << cur_div) - 1);
   assign sys_tick = run && tick_cur && ((cnt & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src <= '0;
         cur_div <= '0;
         cnt     <= '0;
      end else if (req_src != cur_src) begin
         if (rdy_s[req_src]) begin
            cur_src <= req_src;
            cur_div <= req_div;
            cnt     <= '0;
         end else if (run && tick_cur) begin
            cnt <= cnt + 1'b1;
         end
      end else if (req_div != cur_div) begin
         cur_div <= req_div;
         cnt     <= '0;
      end else if (run && tick_cur) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
   import clk_src_sel_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  RST_EN      = 4'b0001,
   parameter logic [3:0]  RST_STOP    = 4'b1111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [3:0]        src_ready,
   input  logic [3:0]        src_tick,
   input  logic              sleep_evt,
   input  logic              wake_evt,
   output logic [3:0]        osc_on,
   output logic              sys_tick
);

   if (DATA_W < 2 * (SRC_W + DIV_W) + 1) begin : g_bad_width
      $error("clk_src_sel: DATA_W too narrow for the selection register");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("clk_src_sel: SYNC_STAGES above 4 is not supported");
   end

   logic [SRC_W-1:0]   req_src;
   logic [DIV_W-1:0]   req_div;
   logic [SRC_W-1:0]   wk_src;
   logic [DIV_W-1:0]   wk_div;
   logic [SRC_W-1:0]   cur_src;
   logic [DIV_W-1:0]   cur_div;
   logic [NUM_SRC-1:0] osc_en;
   logic [NUM_SRC-1:0] sleep_stop;
   logic [NUM_SRC-1:0] rdy_s;
   logic               asleep;
   logic               wake_fire;

   clk_src_sel_regs #(
      .DATA_W   (DATA_W),
      .RST_EN   (RST_EN),
      .RST_STOP (RST_STOP)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .reg_sel    (reg_sel),
      .wdata      (wdata),
      .wake_fire  (wake_fire),
      .rdata      (rdata),
      .req_src    (req_src),
      .req_div    (req_div),
      .wk_src     (wk_src),
      .wk_div     (wk_div),
      .osc_en     (osc_en),
      .sleep_stop (sleep_stop)
   );

   clk_src_sel_power u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_evt  (sleep_evt),
      .wake_evt   (wake_evt),
      .osc_en     (osc_en),
      .sleep_stop (sleep_stop),
      .req_src    (req_src),
      .cur_src    (cur_src),
      .asleep     (asleep),
      .wake_fire  (wake_fire),
      .osc_on     (osc_on)
   );

   clk_src_sel_switch #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sw (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_src   (req_src),
      .req_div   (req_div),
      .src_ready (src_ready),
      .src_tick  (src_tick),
      .asleep    (asleep),
      .cur_src   (cur_src),
      .cur_div   (cur_div),
      .rdy_s     (rdy_s),
      .sys_tick  (sys_tick)
   );

endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk
   import clk_src_sel_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sys_tick,
   input logic [3:0]         osc_on,
   input logic               asleep,
   input logic               sleep_evt,
   input logic [SRC_W-1:0]   cur_src,
   input logic [DIV_W-1:0]   cur_div,
   input logic [SRC_W-1:0]   req_src,
   input logic [DIV_W-1:0]   req_div,
   input logic [SRC_W-1:0]   wk_src,
   input logic [DIV_W-1:0]   wk_div,
   input logic [3:0]         rdy_s,
   input logic [DATA_W-1:0]  rdata
);

   logic [3:0]       rdy_q;
   logic [SRC_W-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= '0;
         cur_q <= '0;
      end else begin
         rdy_q <= rdy_s;
         cur_q <= cur_src;
      end
   end

   // R7
   no_tick_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !sys_tick);

   // R6
   active_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !asleep |-> (osc_on[cur_src] && osc_on[req_src]));

   // R5
   switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_src != cur_q) |-> rdy_q[cur_src]);

   // R3
   legal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok(cur_src, cur_div) && pair_ok(req_src, req_div));

   // R9
   wake_pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pair_ok(wk_src, wk_div));

   // R12
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:9] == '0);

   // R11
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_evt && !asleep) |=> asleep);

endmodule

bind clk_src_sel clk_src_sel_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sys_tick  (sys_tick),
   .osc_on    (osc_on),
   .asleep    (asleep),
   .sleep_evt (sleep_evt),
   .cur_src   (cur_src),
   .cur_div   (cur_div),
   .req_src   (req_src),
   .req_div   (req_div),
   .wk_src    (wk_src),
   .wk_div    (wk_div),
   .rdy_s     (rdy_s),
   .rdata     (rdata)
);

// File: tb/clk_src_sel_tb.sv
module clk_src_sel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  src_ready = 4'hF;
   logic [3:0]  src_tick = 4'h0;
   logic        sleep_evt = 1'b0;
   logic        wake_evt = 1'b0;
   logic [3:0]  osc_on;
   logic        sys_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the programmed state
   logic [1:0] m_src = 0, m_div = 0, m_wsrc = 0, m_wdiv = 0;
   logic       m_wmode = 0;
   logic [3:0] m_en = 4'b0001, m_stop = 4'b1111;

   always #5 clk = ~clk;

   clk_src_sel u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .reg_sel   (reg_sel),
      .wdata     (wdata),
      .rdata     (rdata),
      .src_ready (src_ready),
      .src_tick  (src_tick),
      .sleep_evt (sleep_evt),
      .wake_evt  (wake_evt),
      .osc_on    (osc_on),
      .sys_tick  (sys_tick)
   );

   function automatic bit legal(input logic [1:0] s, input logic [1:0] d);
      if (s == 2'd2) return 1'b1;
      if (s == 2'd3) return d == 2'd0;
      return d < 2'd2;
   endfunction

   function automatic logic [15:0] sel_exp();
      return {7'b0, m_wmode, m_wdiv, m_wsrc, m_div, m_src};
   endfunction

   function automatic logic [3:0] on_exp(input bit slp);
      logic [3:0] v;
      v = m_en | (4'b1 << m_src);
      if (slp) v = v & ~m_stop;
      return v;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic model_sel_write(input logic [15:0] d);
      if (legal(d[1:0], d[3:2])) begin m_src = d[1:0]; m_div = d[3:2]; end
      if (d[5:4] != 2'd1 && legal(d[5:4], d[7:6])) begin m_wsrc = d[5:4]; m_wdiv = d[7:6]; end
      m_wmode = d[8];
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      reg_sel = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      @(negedge clk);
      reg_sel = a;
      #1 v = rdata;
   endtask

   task automatic pulse_sleep();
      @(negedge clk); sleep_evt = 1'b1;
      @(negedge clk); sleep_evt = 1'b0;
   endtask

   task automatic pulse_wake();
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
   endtask

   task automatic count_ticks(input int s, output int n);
      @(negedge clk);
      src_tick = 4'(1 << s);
      n = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (sys_tick) n++;
      end
      src_tick = 4'h0;
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [15:0] v;
      int n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      rd(1'b0, v); check("R1 sel reset", v, 16'h0000);
      rd(1'b1, v); check("R1 pwr reset", v, 16'h00F1);
      check("R1 osc_on reset", 16'(osc_on), 16'h0001);

      // R4 divide by 1 on source 0, other sources ignored
      count_ticks(0, n); check("R4 src0 div1", 16'(n), 16);
      count_ticks(1, n); check("R4 foreign ticks", 16'(n), 0);

      // R2 fast-A divide by 8
      wr(1'b0, 16'h000E); model_sel_write(16'h000E); settle();
      rd(1'b0, v); check("R2 readback", v, sel_exp());
      check("R6 osc_on", 16'(osc_on), 16'(on_exp(0)));
      count_ticks(2, n); check("R4 src2 div8", 16'(n), 2);

      // R3 illegal pair: external with divide by 2
      wr(1'b0, 16'h0007); model_sel_write(16'h0007); settle();
      rd(1'b0, v); check("R3 ignored", v, 16'h000E);
      count_ticks(2, n); check("R3 still src2", 16'(n), 2);

      // R5 switch held until ready
      src_ready = 4'b1101;
      wr(1'b0, 16'h0005); model_sel_write(16'h0005); settle();
      check("R5 both powered", 16'(osc_on), 16'h0007);
      count_ticks(2, n); check("R5 old source drives", 16'(n), 2);
      src_ready = 4'hF; settle();
      count_ticks(1, n); check("R5 new source div2", 16'(n), 8);
      check("R6 old released", 16'(osc_on), 16'(on_exp(0)));

      // R12 reserved bits
      wr(1'b1, 16'hFFFF); rd(1'b1, v); check("R12 pwr reserved", v, 16'h00FF);
      wr(1'b1, 16'h00E1); m_en = 4'b0001; m_stop = 4'b1110;
      rd(1'b1, v); check("R12 pwr value", v, 16'h00E1);
      rd(1'b0, v); check("R12 sel reserved", v, sel_exp());

      // R7 sleep
      pulse_sleep(); settle();
      check("R7 osc_on asleep", 16'(osc_on), 16'(on_exp(1)));
      count_ticks(1, n); check("R7 no tick asleep", 16'(n), 0);
      // R11 second sleep ignored, wake without reload
      pulse_sleep();
      pulse_wake(); settle();
      rd(1'b0, v); check("R8 wake mode off", v, 16'h0005);
      check("R11 awake osc_on", 16'(osc_on), 16'(on_exp(0)));
      count_ticks(1, n); check("R8 running after wake", 16'(n), 8);

      // R9 illegal wake pair (slow source) not stored
      wr(1'b0, 16'h0115); model_sel_write(16'h0115);
      rd(1'b0, v); check("R9 wake slow rejected", v, 16'h0105);
      wr(1'b0, 16'h0175); model_sel_write(16'h0175);
      rd(1'b0, v); check("R9 wake ext div2 rejected", v, 16'h0105);

      // R8 wake reload
      wr(1'b0, 16'h01A5); model_sel_write(16'h01A5);
      pulse_sleep(); pulse_wake(); settle();
      m_src = m_wsrc; m_div = m_wdiv;
      rd(1'b0, v); check("R8 reload", v, 16'h01AA);
      count_ticks(2, n); check("R8 reloaded divider", 16'(n), 4);

      // R11 wake while awake does nothing
      wr(1'b0, 16'h0130); model_sel_write(16'h0130); settle();
      pulse_wake(); settle();
      rd(1'b0, v); check("R11 wake ignored awake", v, 16'h0130);
      count_ticks(0, n); check("R11 src0 running", 16'(n), 16);

      // R10 wake and write in one cycle
      pulse_sleep();
      @(negedge clk);
      reg_sel = 1'b0; wdata = 16'h0134; wr_en = 1'b1; wake_evt = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wake_evt = 1'b0;
      m_src = 2'd3; m_div = 2'd0;
      settle();
      rd(1'b0, v); check("R10 reload wins", v, 16'h0133);
      count_ticks(3, n); check("R10 external runs", 16'(n), 16);

      // R2 R3 random selection writes against the legality model
      for (int i = 0; i < 40; i++) begin
         logic [15:0] d;
         d = 16'($urandom & 32'h1FF);
         wr(1'b0, d); model_sel_write(d); settle();
         rd(1'b0, v); check("R2 R3 random readback", v, sel_exp());
         check("R6 random osc_on", 16'(osc_on), 16'(on_exp(0)));
      end
      count_ticks(int'(m_src), n);
      check("R4 final divider", 16'(n), 16'(16 >> m_div));

      done = 1'b1;
      report();
   end

endmodule